// File: doc/BRIEF.md
# Pipelined Burst Memory with Zero Turnaround

This block is a synchronous single-port memory. Each access has its address and command captured on one active rising edge. The data beat for that access is on the bus two active edges later. Read data is driven after that edge. Write data is sampled at that edge. Reads and writes share the same latency, so any mix of them can be issued on consecutive cycles without an idle slot on the data bus.

A load cycle takes a new address, a read or write command and a per-lane write mask. Up to three following advance cycles walk the two low address bits through a four-beat burst. The order is either linear (offset plus beat, modulo 4) or interleaved (offset XOR beat), chosen by a strap input. The chip is selected by three decoded inputs.

A clock-enable input stalls the whole pipeline, and an asynchronous output-enable input can only turn the bus drivers off. The bidirectional bus is split into an input word, an output word and a drive enable. There is no valid/ready handshake at the edge. Flow is governed by the fixed two-cycle latency, and the clock enable is the only means of back-pressure.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read loaded on active edge k makes `dq_oe` high and puts the stored word on `dq_out` after active edge k+2. A write loaded on edge k stores the `dq_in` value sampled at active edge k+2.
- R2: Reads and writes can be loaded on every consecutive active edge in any order, and each one completes correctly with no idle cycle.
- R3: While `clk_en_n` is high, every synchronous input is ignored and the outputs and the pipeline hold their values. The access in progress resumes when the clock enable returns.
- R4: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load cycle without that decode starts no access and ends any active burst. Accesses already in the pipeline still complete.
- R5: When `ld_n`=1, an active burst advances one beat and reuses the command and lane mask of its load. After four beats the burst wraps to its first beat. When no burst is active, an advance cycle starts nothing.
- R6: With `order_il`=1 the beat offset is start XOR count. With `order_il`=0 it is (start + count) mod 4. The upper address bits stay fixed for the whole burst.
- R7: Lane i is bits [9i+8:9i] of the data word. It is written only when `wr_n`=0 on the load and `lane_wr_n[i]`=0. Lanes that are not selected keep their stored contents.
- R8: `dq_oe` is low during the data beat of a write, during a beat with no access (deselected or idle), and during reset.
- R9: `out_en_n`=1 forces `dq_oe` low immediately, without waiting for a clock edge. `out_en_n`=0 never drives the bus outside a read beat.
- R10: A read loaded one or two active edges after a write to the same address returns the new data, merged lane by lane with the old word.
- R11: After reset the pipeline holds no accesses, no burst is active and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| sel1_n | input | 1 | Select input, active low |
| sel2 | input | 1 | Select input, active high |
| sel3_n | input | 1 | Select input, active low |
| ld_n | input | 1 | 0 loads a new access, 1 advances the burst |
| wr_n | input | 1 | 0 marks the load as a write |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address taken on load |
| order_il | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data beat |
| dq_out | output | LANES*LANE_W | Read data beat |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench runs a full-memory fill in linear write bursts. It follows with a mix of single reads and writes that alternate on every cycle, which separates a correct two-cycle write latency from a read-style or one-cycle one. Reads one and two cycles after a write to the same address, including a partial-lane write, show whether the in-flight write is forwarded or a stale word is returned. Interleaved and linear bursts from odd and even start offsets, deselects in the middle of a burst on each select input, stalls with garbage on the inputs, and toggling of the output-enable input separate the ordering, termination, hold and drive-gating rules.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_offset(
      input logic [BEAT_W-1:0] start,
      input logic [BEAT_W-1:0] beat,
      input logic              interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              sel_ok,
  input  logic              ld_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_il,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_mask
);
  logic              b_act;
  logic              b_write;
  logic [ADDR_W-1:0] b_base;
  logic [LANES-1:0]  b_mask;
  logic [BEAT_W-1:0] b_cnt;
  logic [BEAT_W-1:0] next_cnt;

  assign next_cnt = b_cnt + BEAT_W'(1);

  always_comb begin
    if (!ld_n) begin
      cmd_valid = sel_ok;
      cmd_write = !wr_n;
      cmd_addr  = addr;
      cmd_mask  = ~lane_wr_n;
    end else begin
      cmd_valid = b_act;
      cmd_write = b_write;
      cmd_addr  = {b_base[ADDR_W-1:BEAT_W],
                   beat_offset(b_base[BEAT_W-1:0], next_cnt, order_il)};
      cmd_mask  = b_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act   <= 1'b0;
      b_write <= 1'b0;
      b_base  <= '0;
      b_mask  <= '0;
      b_cnt   <= '0;
    end else if (adv_en) begin
      if (!ld_n) begin
        b_act   <= sel_ok;
        b_write <= !wr_n;
        b_base  <= addr;
        b_mask  <= ~lane_wr_n;
        b_cnt   <= '0;
      end else if (b_act) begin
        b_cnt <= next_cnt;
      end
    end
  end
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv_en,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic                    s2_valid,
  input  logic                    s2_write,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    oe_q
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_cap;
  logic [DATA_W-1:0] rd_merged;
  logic              wr_now;
  logic              hit;

  assign wr_now = adv_en && s2_valid && s2_write;
  assign hit    = s2_valid && s2_write && (s2_addr == s1_addr);

  // Per-lane bypass of the write that commits on this edge.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_merged[g*LANE_W +: LANE_W] = (hit && s2_mask[g])
        ? dq_in[g*LANE_W +: LANE_W]
        : mem[s1_addr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_now) begin
      for (int l = 0; l < LANES; l++) begin
        if (s2_mask[l]) mem[s2_addr][l*LANE_W +: LANE_W] <= dq_in[l*LANE_W +: LANE_W];
      end
    end
    if (adv_en) rd_cap <= rd_merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      rd_q <= '0;
    end else if (adv_en) begin
      oe_q <= s2_valid && !s2_write;
      if (s2_valid && !s2_write) rd_q <= rd_cap;
    end
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    ld_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order_il,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic              adv_en, sel_ok;
  logic              c_valid, c_write;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_mask;
  logic              s1_valid, s1_write, s2_valid, s2_write;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_mask, s2_mask;
  logic              oe_q;

  assign adv_en = !clk_en_n;
  assign sel_ok = !sel1_n && sel2 && !sel3_n;

  sram_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .sel_ok(sel_ok), .ld_n(ld_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr), .order_il(order_il),
    .cmd_valid(c_valid), .cmd_write(c_write), .cmd_addr(c_addr), .cmd_mask(c_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_write <= 1'b0; s1_addr <= '0; s1_mask <= '0;
      s2_valid <= 1'b0; s2_write <= 1'b0; s2_addr <= '0; s2_mask <= '0;
    end else if (adv_en) begin
      s1_valid <= c_valid;  s1_write <= c_write;  s1_addr <= c_addr;  s1_mask <= c_mask;
      s2_valid <= s1_valid; s2_write <= s1_write; s2_addr <= s1_addr; s2_mask <= s1_mask;
    end
  end

  sram_data_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_data (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .s1_addr(s1_addr),
    .s2_valid(s2_valid), .s2_write(s2_write), .s2_addr(s2_addr), .s2_mask(s2_mask),
    .dq_in(dq_in), .rd_q(dq_out), .oe_q(oe_q)
  );

  assign dq_oe = oe_q && !out_en_n;
endmodule

// File: rtl/sram_sva.sv
module sram_sva #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              ld_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              s1_valid,
  input logic              s2_valid,
  input logic              s2_write,
  input logic              oe_q
);
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(dq_out) && $stable(oe_q) && $stable(s2_valid)));

  p_desel_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && !(!sel1_n && sel2 && !sel3_n)) |=> !s1_valid);

  p_idle_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ld_n && !s1_valid) |=> !s1_valid);

  p_read_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_valid && !s2_write) |=> oe_q);

  p_write_beat_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && (!s2_valid || s2_write)) |=> !dq_oe);

  p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);
endmodule

bind pipe_burst_sram sram_sva #(.DATA_W(LANES*LANE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .ld_n(ld_n), .out_en_n(out_en_n), .dq_out(dq_out), .dq_oe(dq_oe),
  .s1_valid(s1_valid), .s2_valid(s2_valid), .s2_write(s2_write), .oe_q(oe_q)
);

// File: tb/sim_pipe_burst_sram.sv
module sim_pipe_burst_sram;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic ld_n = 1'b0, wr_n = 1'b1, order_il = 1'b0, out_en_n = 1'b0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #5 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .ld_n(ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .order_il(order_il), .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0, errors = 0;
  string phase = "R11 reset";
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  typedef struct { bit v; bit w; int a; bit [LN-1:0] m; } cmd_t;
  cmd_t q[$];
  cmd_t c, old;
  logic [DW-1:0] mem_m [1<<AW];
  bit m_act, m_w;
  int m_base, m_cnt, st, off;
  bit [LN-1:0] m_mask;
  bit exp_oe = 0;
  logic [DW-1:0] exp_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      c.v = 0; c.w = 0; c.a = 0; c.m = '0;
      q.push_back(c); q.push_back(c);
      m_act = 0; exp_oe = 0;
    end else if (!clk_en_n) begin
      c.v = 0; c.w = 0; c.a = 0; c.m = '0;
      if (!ld_n) begin
        c.v = !sel1_n && sel2 && !sel3_n;
        c.w = !wr_n; c.a = int'(addr); c.m = ~lane_wr_n;
        m_act = c.v; m_base = int'(addr); m_cnt = 0; m_w = c.w; m_mask = c.m;
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4;
        st = m_base % 4;
        off = order_il ? (st ^ m_cnt) : ((st + m_cnt) % 4);
        c.v = 1; c.w = m_w; c.m = m_mask; c.a = (m_base / 4) * 4 + off;
      end
      q.push_back(c);
      old = q.pop_front();
      exp_oe = 0;
      if (old.v && old.w) begin
        for (int l = 0; l < LN; l++)
          if (old.m[l]) mem_m[old.a][l*LW +: LW] = dq_in[l*LW +: LW];
      end else if (old.v) begin
        exp_oe = 1;
        exp_data = mem_m[old.a];
      end
    end
    #2;
    if (rst_n) begin
      check(dq_oe === (exp_oe && !out_en_n), {phase, " oe"}, DW'(dq_oe), DW'(exp_oe && !out_en_n));
      if (exp_oe) check(dq_out === exp_data, {phase, " data"}, dq_out, exp_data);
    end
  end

  task automatic step(input bit ce, input bit s1, input bit s2v, input bit s3,
                      input bit ld, input bit wr, input bit [LN-1:0] bw, input int a);
    clk_en_n = ce; sel1_n = s1; sel2 = s2v; sel3_n = s3;
    ld_n = ld; wr_n = wr; lane_wr_n = bw; addr = AW'(a);
    dq_in = DW'($urandom);
    @(negedge clk);
  endtask
  task automatic rd(input int a);                 step(0, 0, 1, 0, 0, 1, '1, a); endtask
  task automatic wr(input int a, input bit [LN-1:0] bw); step(0, 0, 1, 0, 0, 0, bw, a); endtask
  task automatic adv();                           step(0, 1, 0, 1, 1, 1, '1, 0); endtask
  task automatic nop();                           step(0, 1, 1, 0, 0, 1, '1, 0); endtask
  task automatic stall();                         step(1, 0, 1, 0, 0, 0, '0, 63); endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dq_oe === 1'b0, "R11 oe during reset", DW'(dq_oe), '0);
    rst_n = 1'b1;
    nop(); nop();
    check(dq_oe === 1'b0, "R11 oe after reset", DW'(dq_oe), '0);

    phase = "R7 R5 fill burst";
    for (int b = 0; b < 16; b++) begin wr(b * 4, '0); adv(); adv(); adv(); end
    nop(); nop();

    phase = "R2 R1 mixed";
    for (int i = 0; i < 12; i++) if (i % 2 == 0) rd((i * 5) % 64); else wr((i * 7) % 64, '0);
    nop(); nop();

    phase = "R10 forwarding";
    wr(20, '0); rd(20); rd(20);
    wr(21, 2'b01); rd(21); nop(); rd(21);
    wr(22, 2'b10); nop(); rd(22);
    nop(); nop();

    phase = "R6 interleaved";
    order_il = 1'b1;
    rd(6); adv(); adv(); adv(); adv();
    rd(9); adv(); adv(); adv();
    nop(); nop();
    phase = "R6 linear";
    order_il = 1'b0;
    rd(7); adv(); adv(); adv();
    rd(13); adv(); adv(); adv();
    nop(); nop();

    phase = "R7 lane mask";
    wr(30, 2'b10); wr(31, 2'b11); rd(30); rd(31); wr(32, 2'b01); rd(32);
    nop(); nop();

    phase = "R4 deselect";
    rd(40); adv(); step(0, 0, 0, 0, 0, 1, '1, 44); adv(); adv();
    rd(41); step(0, 1, 1, 0, 0, 0, '0, 41); adv();
    rd(42); step(0, 0, 1, 1, 0, 1, '1, 42); adv();
    wr(43, '0); adv(); nop(); adv(); rd(43); adv(); adv();
    nop(); nop();

    phase = "R5 idle advance";
    nop(); adv(); adv(); adv();

    phase = "R3 stall";
    rd(44); adv(); stall(); stall(); stall(); adv(); adv();
    wr(50, '0); stall(); stall(); rd(50); stall(); adv(); nop(); nop(); nop();

    phase = "R9 output enable";
    for (int i = 0; i < 6; i++) begin out_en_n = i[0]; rd(i + 1); end
    out_en_n = 1'b0;
    rd(2); nop();
    if (exp_oe) begin
      out_en_n = 1'b1; #1;
      check(dq_oe === 1'b0, "R9 async off", DW'(dq_oe), '0);
      out_en_n = 1'b0; #1;
      check(dq_oe === 1'b1, "R9 async restore", DW'(dq_oe), DW'(1));
    end else check(1'b0, "R9 setup", DW'(exp_oe), DW'(1));
    nop(); nop(); nop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule